// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block turns the core's low-power instructions into clock-enable and power-control outputs. It drives five outputs: a core clock enable, a system clock enable, one peripheral clock enable per peripheral, a PLL power enable and an oscillator power enable. Three operating states are visible to software: Run, Wait and Stop. A fourth state, Relock, exists only while the block waits for the PLL to lock after a deep Stop.

Two allow bits decide whether a WAIT or a STOP request from the core takes effect. A blocked request leaves the block in Run. A deep-stop option bit decides what happens to the PLL and oscillator in Stop:

- With the bit clear, the PLL and oscillator stay powered so that restart is fast.
- With the bit set, both are powered down for the lowest power. The clocks then come back only after the PLL reports lock.

A wake input returns the block to Run. That input stands for an enabled interrupt; an asynchronous reset does the same. Each peripheral also has its own gate input, which can stop that peripheral's clock while the chip is in Run or Wait.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While rst_ni is low, mode_o reads Run (2'b00) and every enable output is 1.
- R2: In Run, a WAIT request (wait_req_i) with wait_allow_i high moves the block to Wait (mode_o 2'b01) at the next edge. In Wait, the core and system enables are 0, the PLL and oscillator enables are 1, and the peripheral enables follow R10.
- R3: In Run, a STOP request (stop_req_i) with stop_allow_i high moves the block to Stop (mode_o 2'b10) at the next edge. In Stop, the core, system and all peripheral enables are 0. If stop_pll_off_i was 0 when Stop was entered, the PLL and oscillator enables stay at 1.
- R4: If stop_pll_off_i was 1 in the cycle the block entered Stop, the PLL and oscillator enables are 0 throughout that Stop. Later changes of stop_pll_off_i have no effect until the next Stop entry.
- R5: A WAIT or STOP request whose allow bit is low leaves mode_o at Run and leaves every output unchanged.
- R6: When WAIT and STOP requests are both allowed in the same Run cycle, STOP wins. When STOP is blocked and WAIT is allowed, WAIT is taken.
- R7: Wake (wake_i) in Wait, or in a Stop with the PLL kept powered, returns the block to Run at the next edge, with every enable at 1 except gated peripherals.
- R8: Wake in a Stop with the PLL powered down moves the block to Relock (mode_o 2'b11). In Relock, the PLL and oscillator enables are 1 and the core, system and peripheral enables are 0. The block moves to Run at the first edge where pll_lock_i is 1.
- R9: WAIT and STOP requests outside Run, and wake in Run, have no effect.
- R10: In Run and Wait, periph_clk_en_o[i] equals the inverse of periph_gate_i[i] sampled at the previous edge.
- R11: Every output is registered. An input change shows up on the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wait_req_i | input | 1 | Core executed WAIT |
| stop_req_i | input | 1 | Core executed STOP |
| wait_allow_i | input | 1 | Allow bit for WAIT |
| stop_allow_i | input | 1 | Allow bit for STOP |
| stop_pll_off_i | input | 1 | Power down PLL and oscillator in Stop |
| wake_i | input | 1 | Wake-up event |
| pll_lock_i | input | 1 | PLL lock indication |
| periph_gate_i | input | NPERIPH | Per-peripheral clock gate, 1 stops that clock |
| mode_o | output | 2 | Current mode: 00 Run, 01 Wait, 10 Stop, 11 Relock |
| core_clk_en_o | output | 1 | Core clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| periph_clk_en_o | output | NPERIPH | Peripheral clock enables |
| pll_en_o | output | 1 | PLL power enable |
| osc_en_o | output | 1 | Oscillator power enable |

## Verification
The assertions assume that every input is synchronous to clk_i and stable around the rising edge. They also assume that pll_lock_i only matters in Relock, so it may take any value at other times. The stimulus drives every input on the falling edge, so these assumptions always hold. The random stimulus keeps requests rare and wake and lock moderately likely. This spreads the run across every mode, including Relock runs of several cycles. Directed cases cover simultaneous requests, a change of the option bit in the middle of Stop, and a wake arriving in the same cycle as a request.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_WAIT   = 2'b01,
    MODE_STOP   = 2'b10,
    MODE_RELOCK = 2'b11
  } lpm_mode_e;
endpackage

// File: rtl/lpm_req_qual.sv
module lpm_req_qual (
  input  logic wait_req_i,
  input  logic stop_req_i,
  input  logic wait_allow_i,
  input  logic stop_allow_i,
  output logic stop_go_o,
  output logic wait_go_o
);
  // stop has priority when both are allowed
  always_comb begin
    stop_go_o = stop_req_i & stop_allow_i;
    wait_go_o = wait_req_i & wait_allow_i & ~stop_go_o;
  end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stop_go_i,
  input  logic      wait_go_i,
  input  logic      stop_pll_off_i,
  input  logic      wake_i,
  input  logic      pll_lock_i,
  output lpm_mode_e mode_q_o,
  output lpm_mode_e mode_d_o,
  output logic      pll_off_q_o,
  output logic      pll_off_d_o
);
  lpm_mode_e mode_q, mode_d;
  logic      pll_off_q, pll_off_d;

  always_comb begin
    mode_d    = mode_q;
    pll_off_d = pll_off_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (stop_go_i) begin
          mode_d    = MODE_STOP;
          pll_off_d = stop_pll_off_i;
        end else if (wait_go_i) begin
          mode_d = MODE_WAIT;
        end
      end
      MODE_WAIT:   if (wake_i) mode_d = MODE_RUN;
      MODE_STOP:   if (wake_i) mode_d = pll_off_q ? MODE_RELOCK : MODE_RUN;
      MODE_RELOCK: if (pll_lock_i) begin
        mode_d    = MODE_RUN;
        pll_off_d = 1'b0;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_RUN;
      pll_off_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      pll_off_q <= pll_off_d;
    end
  end

  assign mode_q_o    = mode_q;
  assign mode_d_o    = mode_d;
  assign pll_off_q_o = pll_off_q;
  assign pll_off_d_o = pll_off_d;

  a_r5_blocked_stays_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && !stop_go_i && !wait_go_i) |=> (mode_q == MODE_RUN));

  a_r6_stop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && stop_go_i) |=> (mode_q == MODE_STOP));

  a_r8_relock_waits_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RELOCK && !pll_lock_i) |=> (mode_q == MODE_RELOCK));

  a_r4_option_held_in_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP && !wake_i) |=> $stable(pll_off_q));

  a_r9_no_req_outside_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WAIT && !wake_i) |=> (mode_q == MODE_WAIT));
endmodule

// File: rtl/lpm_clk_en_regs.sv
module lpm_clk_en_regs
  import lpm_pkg::*;
#(
  parameter int unsigned NPERIPH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  lpm_mode_e          mode_d_i,
  input  logic               pll_off_d_i,
  input  logic [NPERIPH-1:0] periph_gate_i,
  output logic               core_clk_en_o,
  output logic               sys_clk_en_o,
  output logic [NPERIPH-1:0] periph_clk_en_o,
  output logic               pll_en_o,
  output logic               osc_en_o
);
  logic run_d, periph_live_d, pwr_d;

  always_comb begin
    run_d         = (mode_d_i == MODE_RUN);
    periph_live_d = (mode_d_i == MODE_RUN) || (mode_d_i == MODE_WAIT);
    pwr_d         = !((mode_d_i == MODE_STOP) && pll_off_d_i);
  end

  // registered enables: change only at edges, so gated clocks stay clean
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_clk_en_o <= 1'b1;
      sys_clk_en_o  <= 1'b1;
      pll_en_o      <= 1'b1;
      osc_en_o      <= 1'b1;
    end else begin
      core_clk_en_o <= run_d;
      sys_clk_en_o  <= run_d;
      pll_en_o      <= pwr_d;
      osc_en_o      <= pwr_d;
    end
  end

  for (genvar i = 0; i < NPERIPH; i++) begin : g_periph
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) periph_clk_en_o[i] <= 1'b1;
      else         periph_clk_en_o[i] <= periph_live_d & ~periph_gate_i[i];
    end
  end

  a_r11_pll_osc_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_en_o == osc_en_o);
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned NPERIPH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wait_req_i,
  input  logic               stop_req_i,
  input  logic               wait_allow_i,
  input  logic               stop_allow_i,
  input  logic               stop_pll_off_i,
  input  logic               wake_i,
  input  logic               pll_lock_i,
  input  logic [NPERIPH-1:0] periph_gate_i,
  output logic [1:0]         mode_o,
  output logic               core_clk_en_o,
  output logic               sys_clk_en_o,
  output logic [NPERIPH-1:0] periph_clk_en_o,
  output logic               pll_en_o,
  output logic               osc_en_o
);
  logic      stop_go, wait_go, pll_off_q, pll_off_d;
  lpm_mode_e mode_q, mode_d;

  lpm_req_qual u_qual (
    .wait_req_i  (wait_req_i),
    .stop_req_i  (stop_req_i),
    .wait_allow_i(wait_allow_i),
    .stop_allow_i(stop_allow_i),
    .stop_go_o   (stop_go),
    .wait_go_o   (wait_go)
  );

  lpm_mode_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stop_go_i     (stop_go),
    .wait_go_i     (wait_go),
    .stop_pll_off_i(stop_pll_off_i),
    .wake_i        (wake_i),
    .pll_lock_i    (pll_lock_i),
    .mode_q_o      (mode_q),
    .mode_d_o      (mode_d),
    .pll_off_q_o   (pll_off_q),
    .pll_off_d_o   (pll_off_d)
  );

  lpm_clk_en_regs #(.NPERIPH(NPERIPH)) u_en (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_d_i       (mode_d),
    .pll_off_d_i    (pll_off_d),
    .periph_gate_i  (periph_gate_i),
    .core_clk_en_o  (core_clk_en_o),
    .sys_clk_en_o   (sys_clk_en_o),
    .periph_clk_en_o(periph_clk_en_o),
    .pll_en_o       (pll_en_o),
    .osc_en_o       (osc_en_o)
  );

  assign mode_o = mode_q;

  a_r3_stop_clocks_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP) |-> (!core_clk_en_o && !sys_clk_en_o && periph_clk_en_o == '0));

  a_r4_deep_stop_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP) |-> (pll_en_o == !pll_off_q));

  a_r8_relock_power_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RELOCK) |-> (pll_en_o && osc_en_o && !core_clk_en_o && periph_clk_en_o == '0));

  a_r2_wait_core_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WAIT) |-> (!core_clk_en_o && !sys_clk_en_o && pll_en_o));

  a_r7_run_core_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN) |-> (core_clk_en_o && sys_clk_en_o && pll_en_o && osc_en_o));
endmodule

// File: tb/lpm_clk_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_clk_ctrl_bench;
  localparam int NP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_req = 0, stop_req = 0, wait_allow = 0, stop_allow = 0;
  logic pll_off_opt = 0, wake = 0, lock = 0;
  logic [NP-1:0] gate = '0;
  logic [1:0] mode;
  logic core_en, sys_en, pll_en, osc_en;
  logic [NP-1:0] per_en;

  int errors = 0, checks = 0;
  logic [1:0] e_mode = 2'b00;
  logic       e_off = 1'b0;
  logic [NP-1:0] e_gate = '0;

  always #2 clk = ~clk;

  lpm_clk_ctrl #(.NPERIPH(NP)) u_lpm_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wait_req_i(wait_req), .stop_req_i(stop_req),
    .wait_allow_i(wait_allow), .stop_allow_i(stop_allow), .stop_pll_off_i(pll_off_opt),
    .wake_i(wake), .pll_lock_i(lock), .periph_gate_i(gate), .mode_o(mode),
    .core_clk_en_o(core_en), .sys_clk_en_o(sys_en), .periph_clk_en_o(per_en),
    .pll_en_o(pll_en), .osc_en_o(osc_en)
  );

  function automatic logic [NP+5:0] exp_vec(logic [1:0] m, logic off, logic [NP-1:0] g);
    logic run, live, pwr;
    run  = (m == 2'b00);
    live = (m == 2'b00) || (m == 2'b01);
    pwr  = !((m == 2'b10) && off);
    return {m, run, run, live ? ~g : {NP{1'b0}}, pwr, pwr};
  endfunction

  function automatic logic [NP+5:0] act_vec();
    return {mode, core_en, sys_en, per_en, pll_en, osc_en};
  endfunction

  task automatic check(string tag);
    logic [NP+5:0] e, a;
    e = exp_vec(e_mode, e_off, e_gate);
    a = act_vec();
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, a, e, $time);
    end
  endtask

  // reference model advance; returns requirement tag for this transition
  function automatic string model_step();
    string why;
    why = "R10";
    case (e_mode)
      2'b00: begin
        if (stop_req && stop_allow) begin
          why = (wait_req && wait_allow) ? "R6" : (pll_off_opt ? "R4" : "R3");
          e_mode = 2'b10; e_off = pll_off_opt;
        end else if (wait_req && wait_allow) begin
          why = stop_req ? "R6" : "R2"; e_mode = 2'b01;
        end else if (wait_req || stop_req) why = "R5";
        else if (wake) why = "R9";
      end
      2'b01: if (wake) begin e_mode = 2'b00; why = "R7"; end else why = "R9";
      2'b10: if (wake) begin
        why = e_off ? "R8" : "R7"; e_mode = e_off ? 2'b11 : 2'b00;
      end else why = "R9";
      default: begin
        why = "R8";
        if (lock) begin e_mode = 2'b00; e_off = 1'b0; end
      end
    endcase
    e_gate = gate;
    return why;
  endfunction

  // inputs are set beforehand (after a negedge); clock one edge, then check
  task automatic cyc(string tag = "");
    string why;
    @(posedge clk);
    why = model_step();
    @(negedge clk);
    check(tag == "" ? why : tag);
  endtask

  task automatic idle();
    wait_req = 0; stop_req = 0; wake = 0; lock = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    wait_allow = 1; stop_allow = 1;
    cyc("R1");

    // R2 wait entry then wake (R7)
    wait_req = 1; #1; check("R11"); cyc("R2"); idle();
    stop_req = 1; cyc("R9"); idle();
    wake = 1; cyc("R7"); idle();

    // R3 fast stop; option change in stop ignored (R4)
    stop_req = 1; cyc("R3"); idle();
    pll_off_opt = 1; cyc("R4");
    wake = 1; cyc("R7"); idle();

    // R4 deep stop, R8 relock
    stop_req = 1; cyc("R4"); idle(); pll_off_opt = 0;
    cyc("R4");
    wake = 1; cyc("R8"); idle();
    cyc("R8"); cyc("R8");
    lock = 1; cyc("R8"); idle();

    // R5 blocked requests
    wait_allow = 0; stop_allow = 0;
    wait_req = 1; stop_req = 1; cyc("R5"); idle();
    // R6 priority and fallback
    wait_allow = 1; stop_allow = 1; wait_req = 1; stop_req = 1; cyc("R6"); idle();
    wake = 1; cyc("R7"); idle();
    stop_allow = 0; wait_req = 1; stop_req = 1; cyc("R6"); idle();
    wake = 1; wait_req = 1; cyc("R7"); idle();
    // R9 wake in run
    wake = 1; cyc("R9"); idle();
    // R10 peripheral gates in run and wait
    gate = 4'b1010; cyc("R10");
    wait_req = 1; wait_allow = 1; cyc("R10"); idle();
    gate = 4'b0101; cyc("R10");
    wake = 1; cyc("R7"); idle();
    gate = '0;

    for (int n = 0; n < 4000; n++) begin
      wait_allow  = ($urandom % 4) != 0;
      stop_allow  = ($urandom % 4) != 0;
      wait_req    = ($urandom % 6) == 0;
      stop_req    = ($urandom % 6) == 0;
      pll_off_opt = $urandom % 2;
      wake        = ($urandom % 4) == 0;
      lock        = ($urandom % 3) == 0;
      if (($urandom % 8) == 0) gate = NP'($urandom);
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule